// File: doc/BRIEF.md
# Virtual Data Plane Selector

This block sits at the front of a packet pipeline that hosts several virtual data planes on shared hardware. It receives packets as a stream of 64-bit beats with start and end markers. It takes the source MAC address from the Ethernet header, which spans the first two beats, and looks that address up in a small table that software programs. The lookup yields a plane identifier. The block then sends the packet on with a 64-bit control header as the first beat. The header carries the plane identifier, a per-plane mask that selects which downstream functions run, and a per-plane parameter. Its low 32 bits are left at zero so that a later stage can fill in a hash.

Software writes the table entries and the per-plane header fields through a simple register port. Those writes land in a shadow copy. The copy used for lookups is refreshed from the shadow only while no packet is in flight, so a packet is never classified against a half-written table. Backpressure on the output holds the input off, and no beat is dropped.

Top module: `vdpSelector`

## Requirements
- R1: The source MAC of a packet is bits [15:0] of the first beat (MAC bits 47:32) followed by bits [63:32] of the second beat (MAC bits 31:0). If a valid table entry holds that MAC, the entry's plane id is used. When several valid entries match, the entry with the lowest index wins.
- R2: A packet whose source MAC matches no valid entry is assigned plane 0.
- R3: The first output beat of every packet carries outSop and holds the header. Bits [63:60] are the plane id, bits [59:48] are the mask configured for that plane, bits [47:32] are the parameter configured for that plane, and bits [31:0] are zero.
- R4: After the header, every input beat of the packet appears unchanged and in order. outEop is set only on the last beat, and outSop appears only on the header.
- R5: While outValid is high and outReady is low, outData, outSop and outEop hold their values. No beat is lost or duplicated under any pattern of backpressure.
- R6: Register map. regAddr[5:4] selects the kind and regAddr[3:0] selects the index. Kind 0 holds MAC[31:0] of an entry. Kind 1 holds MAC[47:32] in [15:0], the plane id in [19:16] and the valid flag in bit 31 of an entry. Kind 2 holds the plane's mask in [11:0] and its parameter in [31:16]. Kind 3 ignores writes and reads as zero. Reads return the last value written, with unused bits zero.
- R7: A register write made after a packet's first beat has been accepted does not change that packet's header. The write does apply to the next packet.
- R8: While no packet is open, beats without inSop are accepted and discarded and produce no output.
- R9: A packet of a single beat (inSop and inEop together) produces the header followed by that one beat with outEop. MAC bits 31:0 that the packet does not supply are taken as zero.
- R10: After reset, outValid is low, every table entry is invalid, and every plane's mask and parameter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inData | input | 64 | Input beat data, first byte in [63:56] |
| inSop | input | 1 | First beat of a packet |
| inEop | input | 1 | Last beat of a packet |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream can take a beat |
| outData | output | 64 | Output beat data |
| outSop | output | 1 | Header beat marker |
| outEop | output | 1 | Last beat marker |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr, combinational |

## Verification
The bench places the same MAC in two entries with different planes. A design with the wrong priority gives the header the higher entry's plane. It stalls a packet after its first beat and rewrites the matching entry. A design that commits the write at once puts the new plane in that packet's header instead of the next one's. Single-beat packets, stray beats without a start marker and random gaps on both sides of the stream are also applied. A design that mishandles these emits phantom beats, drops a beat, or duplicates one.

// File: rtl/vdpPkg.sv
package vdpPkg;

  typedef enum logic [1:0] {
    SEL_HDR  = 2'd0,
    SEL_B0   = 2'd1,
    SEL_B1   = 2'd2,
    SEL_PASS = 2'd3
  } outSel_e;

  // strobes from control to datapath and table
  typedef struct packed {
    logic    capB0;
    logic    capB1;
    logic    commitTable;
    outSel_e outSel;
  } ctrlStb_t;

endpackage

// File: rtl/vdpTable.sv
module vdpTable
  import vdpPkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PLANE_W     = 4,
  parameter int MASK_W      = 12,
  parameter int PARAM_W     = 16,
  parameter int MAC_W       = 48,
  parameter int REG_W       = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int ADDR_W     = 2 + IDX_W,
  localparam int NUM_PLANES = 1 << PLANE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               commit,
  input  logic [MAC_W-1:0]   lookupMac,
  output logic [PLANE_W-1:0] hitPlane,
  output logic [MASK_W-1:0]  planeMask,
  output logic [PARAM_W-1:0] planeParam
);

  localparam int MACHI_W = MAC_W - 32;

  // shadow copy, written by software
  logic [MAC_W-1:0]   shMac   [NUM_ENTRIES];
  logic [PLANE_W-1:0] shPlane [NUM_ENTRIES];
  logic               shValid [NUM_ENTRIES];
  logic [MASK_W-1:0]  shMask  [NUM_PLANES];
  logic [PARAM_W-1:0] shParam [NUM_PLANES];

  // active copy, used by lookups
  logic [MAC_W-1:0]   acMac   [NUM_ENTRIES];
  logic [PLANE_W-1:0] acPlane [NUM_ENTRIES];
  logic               acValid [NUM_ENTRIES];
  logic [MASK_W-1:0]  acMask  [NUM_PLANES];
  logic [PARAM_W-1:0] acParam [NUM_PLANES];

  logic [1:0]         regKind;
  logic [IDX_W-1:0]   regIdx;
  logic [PLANE_W-1:0] regPlane;
  logic [NUM_ENTRIES-1:0] hitVec;

  assign regKind  = regAddr[ADDR_W-1 -: 2];
  assign regIdx   = regAddr[IDX_W-1:0];
  assign regPlane = regAddr[PLANE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        shMac[i]   <= '0;
        shPlane[i] <= '0;
        shValid[i] <= 1'b0;
      end
      for (int p = 0; p < NUM_PLANES; p++) begin
        shMask[p]  <= '0;
        shParam[p] <= '0;
      end
    end else if (regWrEn) begin
      case (regKind)
        2'd0: shMac[regIdx][31:0] <= regWrData[31:0];
        2'd1: begin
          shMac[regIdx][MAC_W-1:32] <= regWrData[MACHI_W-1:0];
          shPlane[regIdx]           <= regWrData[16 +: PLANE_W];
          shValid[regIdx]           <= regWrData[31];
        end
        2'd2: begin
          shMask[regPlane]  <= regWrData[MASK_W-1:0];
          shParam[regPlane] <= regWrData[16 +: PARAM_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        acMac[i]   <= '0;
        acPlane[i] <= '0;
        acValid[i] <= 1'b0;
      end
      for (int p = 0; p < NUM_PLANES; p++) begin
        acMask[p]  <= '0;
        acParam[p] <= '0;
      end
    end else if (commit) begin
      acMac   <= shMac;
      acPlane <= shPlane;
      acValid <= shValid;
      acMask  <= shMask;
      acParam <= shParam;
    end
  end

  always_comb begin
    regRdData = '0;
    case (regKind)
      2'd0: regRdData[31:0] = shMac[regIdx][31:0];
      2'd1: begin
        regRdData[MACHI_W-1:0]   = shMac[regIdx][MAC_W-1:32];
        regRdData[16 +: PLANE_W] = shPlane[regIdx];
        regRdData[31]            = shValid[regIdx];
      end
      2'd2: begin
        regRdData[MASK_W-1:0]    = shMask[regPlane];
        regRdData[16 +: PARAM_W] = shParam[regPlane];
      end
      default: regRdData = '0;
    endcase
  end

  // one comparator per entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gCmp
    assign hitVec[g] = acValid[g] && (acMac[g] == lookupMac);
  end

  // lowest matching index wins; miss gives plane 0
  always_comb begin
    hitPlane = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) hitPlane = acPlane[i];
    end
  end

  assign planeMask  = acMask[hitPlane];
  assign planeParam = acParam[hitPlane];

endmodule

// File: rtl/vdpDatapath.sv
module vdpDatapath
  import vdpPkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int PLANE_W = 4,
  parameter int MASK_W  = 12,
  parameter int PARAM_W = 16,
  parameter int MAC_W   = 48,
  localparam int HASH_W = DATA_W - PLANE_W - MASK_W - PARAM_W,
  localparam int MACHI_W = MAC_W - 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [DATA_W-1:0]  inData,
  output logic [MAC_W-1:0]   lookupMac,
  input  logic [PLANE_W-1:0] hitPlane,
  input  logic [MASK_W-1:0]  planeMask,
  input  logic [PARAM_W-1:0] planeParam,
  output logic [DATA_W-1:0]  outData
);

  logic [DATA_W-1:0] beat0;
  logic [DATA_W-1:0] beat1;
  logic [DATA_W-1:0] header;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beat0 <= '0;
      beat1 <= '0;
    end else if (stb.capB0) begin
      beat0 <= inData;
      beat1 <= '0;          // single-beat packets see zeros here
    end else if (stb.capB1) begin
      beat1 <= inData;
    end
  end

  assign lookupMac = {beat0[MACHI_W-1:0], beat1[DATA_W-1 -: 32]};
  assign header    = {hitPlane, planeMask, planeParam, {HASH_W{1'b0}}};

  always_comb begin
    case (stb.outSel)
      SEL_HDR:  outData = header;
      SEL_B0:   outData = beat0;
      SEL_B1:   outData = beat1;
      default:  outData = inData;
    endcase
  end

endmodule

// File: rtl/vdpCtrl.sv
module vdpCtrl
  import vdpPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inSop,
  input  logic     inEop,
  output logic     inReady,
  output logic     outValid,
  input  logic     outReady,
  output logic     outSop,
  output logic     outEop,
  output ctrlStb_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_B1, ST_HDR, ST_OUT0, ST_OUT1, ST_PASS
  } state_e;

  state_e state, nextState;
  logic   lenOne;
  logic   b1Last;

  always_comb begin
    nextState       = state;
    inReady         = 1'b0;
    outValid        = 1'b0;
    outSop          = 1'b0;
    outEop          = 1'b0;
    stb             = '0;
    stb.outSel      = SEL_HDR;
    case (state)
      ST_IDLE: begin
        inReady         = 1'b1;
        stb.commitTable = 1'b1;
        if (inValid && inSop) begin
          stb.capB0 = 1'b1;
          nextState = inEop ? ST_HDR : ST_B1;
        end
      end
      ST_B1: begin
        inReady = 1'b1;
        if (inValid) begin
          stb.capB1 = 1'b1;
          nextState = ST_HDR;
        end
      end
      ST_HDR: begin
        outValid   = 1'b1;
        outSop     = 1'b1;
        stb.outSel = SEL_HDR;
        if (outReady) nextState = ST_OUT0;
      end
      ST_OUT0: begin
        outValid   = 1'b1;
        outEop     = lenOne;
        stb.outSel = SEL_B0;
        if (outReady) nextState = lenOne ? ST_IDLE : ST_OUT1;
      end
      ST_OUT1: begin
        outValid   = 1'b1;
        outEop     = b1Last;
        stb.outSel = SEL_B1;
        if (outReady) nextState = b1Last ? ST_IDLE : ST_PASS;
      end
      default: begin
        outValid   = inValid;
        inReady    = outReady;
        outEop     = inEop;
        stb.outSel = SEL_PASS;
        if (inValid && outReady && inEop) nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lenOne <= 1'b0;
      b1Last <= 1'b0;
    end else begin
      state <= nextState;
      if (stb.capB0) lenOne <= inEop;
      if (stb.capB1) b1Last <= inEop;
    end
  end

endmodule

// File: rtl/vdpSelector.sv
module vdpSelector
  import vdpPkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int PLANE_W     = 4,
  parameter int MASK_W      = 12,
  parameter int PARAM_W     = 16,
  parameter int MAC_W       = 48,
  parameter int DATA_W      = 64,
  parameter int REG_W       = 32,
  localparam int ADDR_W     = 2 + $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSop,
  input  logic              inEop,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outSop,
  output logic              outEop,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData
);

  ctrlStb_t           ctrlStb;
  logic [MAC_W-1:0]   lookupMac;
  logic [PLANE_W-1:0] hitPlane;
  logic [MASK_W-1:0]  planeMask;
  logic [PARAM_W-1:0] planeParam;

  vdpCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inSop    (inSop),
    .inEop    (inEop),
    .inReady  (inReady),
    .outValid (outValid),
    .outReady (outReady),
    .outSop   (outSop),
    .outEop   (outEop),
    .stb      (ctrlStb)
  );

  vdpTable #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .PLANE_W     (PLANE_W),
    .MASK_W      (MASK_W),
    .PARAM_W     (PARAM_W),
    .MAC_W       (MAC_W),
    .REG_W       (REG_W)
  ) u_table (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .commit     (ctrlStb.commitTable),
    .lookupMac  (lookupMac),
    .hitPlane   (hitPlane),
    .planeMask  (planeMask),
    .planeParam (planeParam)
  );

  vdpDatapath #(
    .DATA_W  (DATA_W),
    .PLANE_W (PLANE_W),
    .MASK_W  (MASK_W),
    .PARAM_W (PARAM_W),
    .MAC_W   (MAC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (ctrlStb),
    .inData     (inData),
    .lookupMac  (lookupMac),
    .hitPlane   (hitPlane),
    .planeMask  (planeMask),
    .planeParam (planeParam),
    .outData    (outData)
  );

endmodule

// File: rtl/vdpSelectorChecker.sv
module vdpSelectorChecker
  import vdpPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        outValid,
  input logic        outReady,
  input logic        outSop,
  input logic        outEop,
  input logic [63:0] outData,
  input ctrlStb_t    stb
);

  // R5: a stalled output beat holds still
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSop) && $stable(outEop)));

  // R3: hash field of the header is left zero
  assert_hash_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> (outData[31:0] == 32'h0));

  // R4: the beat after a header is never another header
  assert_sop_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outSop) |=> !outSop);

  // R4: after an end beat the next output beat opens a new packet
  assert_eop_then_hdr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outEop) |=> (!outValid || outSop));

  // R7: the active table is refreshed only while no packet is leaving
  assert_commit_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !stb.commitTable);

endmodule

bind vdpSelector vdpSelectorChecker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .outReady (outReady),
  .outSop   (outSop),
  .outEop   (outEop),
  .outData  (outData),
  .stb      (ctrlStb)
);

// File: tb/vdpSelector_tb.sv
`timescale 1ns/1ps
module vdpSelector_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inData = '0;
  logic        inSop = 1'b0;
  logic        inEop = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outData;
  logic        outSop;
  logic        outEop;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;
  int readyPct = 75;

  // bench model of the register state
  logic [47:0] mMac   [16];
  logic [3:0]  mPlane [16];
  logic        mValid [16];
  logic [11:0] mMask  [16];
  logic [15:0] mParam [16];

  // expected output beats
  logic [63:0] expD [$];
  logic        expS [$];
  logic        expE [$];
  string       expTag [$];

  always #2 clk = ~clk;

  vdpSelector u_dut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inData(inData), .inSop(inSop), .inEop(inEop),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSop(outSop), .outEop(outEop),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  function automatic logic [63:0] expHeader(logic [47:0] mac, output string tag);
    logic [3:0] pl = 4'd0;
    tag = "R2 miss";
    for (int i = 15; i >= 0; i--) begin
      if (mValid[i] && mMac[i] == mac) begin
        pl = mPlane[i];
        tag = "R1 hit";
      end
    end
    return {pl, mMask[pl], mParam[pl], 32'h0};
  endfunction

  function automatic logic [31:0] expRead(logic [5:0] a);
    logic [3:0] ix = a[3:0];
    case (a[5:4])
      2'd0: return mMac[ix][31:0];
      2'd1: return {mValid[ix], 11'h0, mPlane[ix], mMac[ix][47:32]};
      2'd2: return {mParam[ix], 4'h0, mMask[ix]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic regWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a[5:4])
      2'd0: mMac[a[3:0]][31:0] = d;
      2'd1: begin
        mMac[a[3:0]][47:32] = d[15:0];
        mPlane[a[3:0]] = d[19:16];
        mValid[a[3:0]] = d[31];
      end
      2'd2: begin
        mMask[a[3:0]] = d[11:0];
        mParam[a[3:0]] = d[31:16];
      end
      default: ;
    endcase
  endtask

  task automatic regCheck(logic [5:0] a);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == expRead(a), "R6 readback", {32'h0, regRdData}, {32'h0, expRead(a)});
  endtask

  task automatic setEntry(int ix, logic [47:0] mac, logic [3:0] pl, bit v);
    regWrite({2'd0, 4'(ix)}, mac[31:0]);
    regWrite({2'd1, 4'(ix)}, {v, 11'h0, pl, mac[47:32]});
  endtask

  task automatic driveBeat(logic [63:0] d, bit s, bit e, int gaps);
    bit acc;
    repeat (gaps) begin
      @(negedge clk);
      inValid = 1'b0;
    end
    @(negedge clk);
    inValid = 1'b1; inData = d; inSop = s; inEop = e;
    forever begin
      #1;
      acc = inReady;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (expD.size() != 0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
  endtask

  // sends a packet; optionally rewrites a register after its first beat
  task automatic sendPacket(logic [47:0] mac, int nBeats, int maxGap,
                            bit midWr, logic [5:0] wa, logic [31:0] wd);
    logic [63:0] beats [8];
    logic [47:0] seen;
    string tag;
    for (int i = 0; i < nBeats; i++) beats[i] = {$urandom, $urandom};
    beats[0][15:0] = mac[47:32];
    if (nBeats > 1) beats[1][63:32] = mac[31:0];
    seen = (nBeats > 1) ? mac : {mac[47:32], 32'h0};
    expD.push_back(expHeader(seen, tag));
    expS.push_back(1'b1); expE.push_back(1'b0);
    expTag.push_back({"R3 header ", tag});
    for (int i = 0; i < nBeats; i++) begin
      expD.push_back(beats[i]); expS.push_back(1'b0);
      expE.push_back(i == nBeats - 1);
      expTag.push_back((nBeats == 1) ? "R9 single beat" : "R4 payload");
    end
    for (int i = 0; i < nBeats; i++) begin
      driveBeat(beats[i], i == 0, i == nBeats - 1, (maxGap > 0) ? ($urandom % (maxGap + 1)) : 0);
      if (i == 0 && midWr && nBeats > 1) begin
        @(negedge clk);
        inValid = 1'b0;
        regWrite(wa, wd);
      end
    end
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  // receiver: compares every accepted output beat
  initial begin
    forever begin
      @(negedge clk);
      outReady = ($urandom % 100) < readyPct;
      #1;
      if (rstN && outValid && outReady) begin
        if (expD.size() == 0) begin
          check(1'b0, "R8 unexpected output beat", outData, 64'h0);
        end else begin
          check(outData == expD[0] && outSop == expS[0] && outEop == expE[0],
                expTag[0], outData, expD[0]);
          if (outSop != expS[0] || outEop != expE[0])
            $display("  markers sop/eop actual=%0d/%0d expected=%0d/%0d",
                     outSop, outEop, expS[0], expE[0]);
          void'(expD.pop_front()); void'(expS.pop_front());
          void'(expE.pop_front()); void'(expTag.pop_front());
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      check(1'b0, "watchdog expired", 64'h0, 64'h1);
      finishRun();
    end
  end

  initial begin
    logic [47:0] macs [16];
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 16; i++) begin
      mMac[i] = '0; mPlane[i] = '0; mValid[i] = 1'b0; mMask[i] = '0; mParam[i] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: reset state
    check(outValid == 1'b0, "R10 outValid after reset", {63'h0, outValid}, 64'h0);
    regCheck({2'd1, 4'd5});
    regCheck({2'd2, 4'd9});

    // R10/R2: empty table gives plane 0 and zero fields
    sendPacket(48'h0A0B0C0D0E0F, 3, 1, 1'b0, '0, '0);
    drain();

    // program entries and plane configs
    for (int i = 0; i < 8; i++) begin
      macs[i] = {$urandom, $urandom};
      setEntry(i, macs[i], 4'($urandom), 1'b1);
    end
    for (int p = 0; p < 16; p++) regWrite({2'd2, 4'(p)}, $urandom);
    for (int i = 0; i < 4; i++) begin
      regCheck({2'd0, 4'(i)});
      regCheck({2'd1, 4'(i)});
      regCheck({2'd2, 4'(i + 3)});
    end
    // R6: kind 3 ignores writes and reads zero
    regWrite(6'h35, 32'hFFFF_FFFF);
    regCheck(6'h35);

    // R1: duplicate MAC, lowest index wins
    macs[9] = 48'h1234_5678_9ABC;
    setEntry(12, macs[9], 4'd7, 1'b1);
    setEntry(9,  macs[9], 4'd3, 1'b1);
    sendPacket(macs[9], 4, 0, 1'b0, '0, '0);
    drain();
    // R1: invalid lower entry is skipped
    setEntry(9, macs[9], 4'd3, 1'b0);
    sendPacket(macs[9], 2, 1, 1'b0, '0, '0);
    drain();

    // R9: single-beat packet, low MAC bits read as zero
    setEntry(10, {16'hBEEF, 32'h0}, 4'd11, 1'b1);
    sendPacket({16'hBEEF, 32'h1111_2222}, 1, 0, 1'b0, '0, '0);
    drain();

    // R8: stray beats while idle
    for (int k = 0; k < 3; k++) driveBeat({$urandom, $urandom}, 1'b0, k == 1, 0);
    @(negedge clk); inValid = 1'b0;
    sendPacket(macs[2], 3, 0, 1'b0, '0, '0);
    drain();

    // R7: write after first beat leaves this header alone, applies to next
    sendPacket(macs[2], 3, 0, 1'b1, {2'd1, 4'd2}, {1'b1, 11'h0, 4'(mPlane[2] + 4'd1), macs[2][47:32]});
    drain();
    sendPacket(macs[2], 3, 0, 1'b0, '0, '0);
    drain();

    // random traffic with occasional reconfiguration between packets
    for (int n = 0; n < 150; n++) begin
      logic [47:0] mac;
      readyPct = (n < 50) ? 100 : ((n < 100) ? 60 : 30);
      if ($urandom % 8 == 0) begin
        int ix = $urandom % 8;
        setEntry(ix, macs[ix], 4'($urandom), ($urandom % 4) != 0);
        regWrite({2'd2, 4'($urandom)}, $urandom);
      end
      mac = (($urandom % 5) == 0) ? {$urandom, $urandom} : macs[$urandom % 8];
      sendPacket(mac, 1 + ($urandom % 6), 2, 1'b0, '0, '0);
      drain();
    end

    readyPct = 100;
    drain();
    check(expD.size() == 0, "R5 all beats delivered", 64'(expD.size()), 64'h0);
    done = 1'b1;
    finishRun();
  end

endmodule